// File: doc/BRIEF.md
# Branch and Jump Resolution Unit

This block decides, within a single cycle, where a 32-bit core with one architectural delay slot fetches from after a control-transfer instruction. The decode stage supplies the address of the control instruction, its six-bit primary opcode, the 26-bit jump field, the 16-bit offset field and the two register operands that have already been read. The block returns the resolved target, a taken indication, the next sequential-or-target fetch address, a request to squash the delay-slot instruction, and a register write for the call form.

Two jump forms are handled: plain jump and jump-and-link. Four compare conditions are handled: equal, not equal, signed at-most-zero and signed greater-than-zero. Each condition exists in a normal form and a "likely" form. In the likely form the instruction in the delay slot only executes when the branch goes. When a likely branch falls through, the squash output tells the pipeline to discard that delay-slot instruction. The unit is purely combinational and holds no state.

Top module: `bru_next_pc`

## Requirements
- R1: For opcode 0x02 (jump) and 0x03 (jump-and-link), taken is high and the target is bits 31..28 of the current PC, followed by the 26-bit jump field, followed by two zero bits.
- R2: For opcode 0x03 only, the link write enable is high, the link register index is 31 and the link data is the current PC plus 8. For every other opcode the link write enable is low.
- R3: For a conditional branch (opcodes 0x04 to 0x07 and 0x14 to 0x17), the target is the current PC plus 4 plus the sign-extended 16-bit offset multiplied by 4, computed modulo 2^32.
- R4: Opcode 0x04 is taken when the two operands are equal, and opcode 0x05 is taken when they differ.
- R5: Opcode 0x06 is taken when the first operand, read as a signed 32-bit number, is zero or negative. Opcode 0x07 is taken when it is strictly positive. The second operand has no effect on either.
- R6: Opcodes 0x14, 0x15, 0x16 and 0x17 use the conditions of 0x04, 0x05, 0x06 and 0x07 respectively. When such a branch is not taken, the annul output is high.
- R7: The annul output is low for every non-likely branch, for every jump, and for a likely branch that is taken.
- R8: The next-PC output equals the target when taken is high, and equals the current PC plus 4 (modulo 2^32) when taken is low.
- R9: For any opcode outside 0x02 to 0x07 and 0x14 to 0x17, taken, annul and link write enable are all low, and the next PC is the current PC plus 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_i | input | 32 | Address of the control instruction |
| opcode_i | input | 6 | Primary opcode field |
| jfield_i | input | 26 | Jump target field |
| offset_i | input | 16 | Signed branch offset field, in words |
| opa_i | input | 32 | First register operand |
| opb_i | input | 32 | Second register operand |
| target_pc_o | output | 32 | Resolved jump or branch target (PC plus 4 for other opcodes) |
| next_pc_o | output | 32 | Target when taken, otherwise PC plus 4 |
| taken_o | output | 1 | Control transfer goes |
| annul_o | output | 1 | Squash the delay-slot instruction |
| link_we_o | output | 1 | Write request for the link register |
| link_idx_o | output | 5 | Link register index |
| link_data_o | output | 32 | Return address to write |

## Verification
The bound checker checks whenever an input changes that a squash never coincides with a taken transfer. It also checks that a link write always carries register 31 and the return address PC plus 8, that both jump opcodes always report taken with the upper PC bits preserved, that a fall-through always yields PC plus 4, and that unlisted opcodes raise nothing. Only the bench scenarios can show the conditions themselves. These are signed versus unsigned treatment of the most negative operand, the negative offset, address wraparound at the top of the address space, and the pairing of each likely opcode with the correct condition.

// File: rtl/bru_pkg.sv
// Shared constants and types for the branch/jump resolution unit.
// Assumes a 32-bit address space with 4-byte instructions.
package bru_pkg;
    localparam int XLEN      = 32;
    localparam int OPC_W     = 6;
    localparam int JFIELD_W  = 26;
    localparam int OFF_W     = 16;
    localparam int RIDX_W    = 5;
    localparam int INSN_B    = 4;
    localparam int LINK_REG  = 31;
    localparam int PC_KEEP_W = XLEN - JFIELD_W - 2;

    // Compare condition; encoding equals opcode bits 1:0 of the branch rows
    typedef enum logic [1:0] {
        CND_EQ  = 2'd0,
        CND_NE  = 2'd1,
        CND_LEZ = 2'd2,
        CND_GTZ = 2'd3
    } cond_e;

    // Result of decoding one opcode
    typedef struct packed {
        logic  jump;
        logic  link;
        logic  branch;
        logic  likely;
        cond_e cond;
    } ctl_s;
endpackage

// File: rtl/bru_decode.sv
// Opcode classifier. Splits the primary opcode into jump, call, branch and
// likely flags plus the compare condition. Assumes only the opcode rows
// named in the brief are control transfers; all others decode to no-op.
module bru_decode
    import bru_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    output ctl_s             ctl_o
);
    localparam logic [OPC_W-1:0] OP_J    = 6'h02;
    localparam logic [OPC_W-1:0] OP_JAL  = 6'h03;
    localparam logic [OPC_W-3:0] ROW_BR  = 4'h1;  // 0x04..0x07
    localparam logic [OPC_W-3:0] ROW_BRL = 4'h5;  // 0x14..0x17

    // Classify opcode into control flags
    always_comb begin
        ctl_o        = '0;
        ctl_o.cond   = cond_e'(opcode_i[1:0]);
        ctl_o.jump   = (opcode_i == OP_J) || (opcode_i == OP_JAL);
        ctl_o.link   = (opcode_i == OP_JAL);
        ctl_o.branch = (opcode_i[OPC_W-1:2] == ROW_BR) ||
                       (opcode_i[OPC_W-1:2] == ROW_BRL);
        ctl_o.likely = (opcode_i[OPC_W-1:2] == ROW_BRL);
    end
endmodule

// File: rtl/bru_cond_eval.sv
// Compare-condition evaluator. Produces the branch outcome for one of four
// conditions on two operands. Assumes two's-complement operands.
module bru_cond_eval
    import bru_pkg::*;
#(
    parameter int W = XLEN
) (
    input  cond_e        cond_i,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    output logic         hit_o
);
    logic same;
    logic a_zero;
    logic a_neg;

    // Basic operand relations
    always_comb begin
        same   = (opa_i == opb_i);
        a_zero = (opa_i == '0);
        a_neg  = opa_i[W-1];
    end

    // Select the requested condition
    always_comb begin
        unique case (cond_i)
            CND_EQ:  hit_o = same;
            CND_NE:  hit_o = !same;
            CND_LEZ: hit_o = a_neg || a_zero;
            CND_GTZ: hit_o = !a_neg && !a_zero;
            default: hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/bru_addr_gen.sv
// Address generator. Forms the region-relative jump target, the PC-relative
// branch target, the fall-through address and the return address. All sums
// wrap modulo 2^XLEN.
module bru_addr_gen
    import bru_pkg::*;
(
    input  logic [XLEN-1:0]     pc_i,
    input  logic [JFIELD_W-1:0] jfield_i,
    input  logic [OFF_W-1:0]    offset_i,
    output logic [XLEN-1:0]     jump_tgt_o,
    output logic [XLEN-1:0]     br_tgt_o,
    output logic [XLEN-1:0]     seq_o,
    output logic [XLEN-1:0]     ret_o
);
    localparam int SEXT_W = XLEN - OFF_W - 2;

    logic [XLEN-1:0] disp;

    // Sign-extend the word offset into a byte displacement
    always_comb begin
        disp = {{SEXT_W{offset_i[OFF_W-1]}}, offset_i, 2'b00};
    end

    // Build the four candidate addresses
    always_comb begin
        seq_o      = pc_i + XLEN'(INSN_B);
        ret_o      = pc_i + XLEN'(2 * INSN_B);
        br_tgt_o   = seq_o + disp;
        jump_tgt_o = {pc_i[XLEN-1 -: PC_KEEP_W], jfield_i, 2'b00};
    end
endmodule

// File: rtl/bru_next_pc.sv
// Top of the branch/jump resolution unit. Purely combinational: decodes the
// opcode, evaluates the compare, and selects target, next PC, squash and
// link outputs. Assumes the operands are already forwarded.
module bru_next_pc
    import bru_pkg::*;
(
    input  logic [31:0] pc_i,
    input  logic [5:0]  opcode_i,
    input  logic [25:0] jfield_i,
    input  logic [15:0] offset_i,
    input  logic [31:0] opa_i,
    input  logic [31:0] opb_i,
    output logic [31:0] target_pc_o,
    output logic [31:0] next_pc_o,
    output logic        taken_o,
    output logic        annul_o,
    output logic        link_we_o,
    output logic [4:0]  link_idx_o,
    output logic [31:0] link_data_o
);
    ctl_s            ctl;
    logic            hit;
    logic [XLEN-1:0] jump_tgt;
    logic [XLEN-1:0] br_tgt;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] ret_pc;

    bru_decode u_dec (
        .opcode_i (opcode_i),
        .ctl_o    (ctl)
    );

    bru_cond_eval #(.W(XLEN)) u_cnd (
        .cond_i (ctl.cond),
        .opa_i  (opa_i),
        .opb_i  (opb_i),
        .hit_o  (hit)
    );

    bru_addr_gen u_adr (
        .pc_i       (pc_i),
        .jfield_i   (jfield_i),
        .offset_i   (offset_i),
        .jump_tgt_o (jump_tgt),
        .br_tgt_o   (br_tgt),
        .seq_o      (seq_pc),
        .ret_o      (ret_pc)
    );

    // Resolve outcome and target
    always_comb begin
        taken_o     = ctl.jump || (ctl.branch && hit);
        annul_o     = ctl.likely && !hit;
        target_pc_o = ctl.jump ? jump_tgt : (ctl.branch ? br_tgt : seq_pc);
        next_pc_o   = taken_o ? target_pc_o : seq_pc;
    end

    // Link register request for the call form
    always_comb begin
        link_we_o   = ctl.link;
        link_idx_o  = RIDX_W'(LINK_REG);
        link_data_o = ret_pc;
    end
endmodule

// File: rtl/bru_next_pc_chk.sv
// Property checker for bru_next_pc, bound to every instance. Evaluates
// immediate assertions whenever the ports change.
module bru_next_pc_chk (
    input logic [31:0] pc_i,
    input logic [5:0]  opcode_i,
    input logic [25:0] jfield_i,
    input logic [31:0] target_pc_o,
    input logic [31:0] next_pc_o,
    input logic        taken_o,
    input logic        annul_o,
    input logic        link_we_o,
    input logic [4:0]  link_idx_o,
    input logic [31:0] link_data_o
);
    logic is_ctl;

    // Opcode belongs to a listed control row
    always_comb begin
        is_ctl = (opcode_i[5:1] == 5'h01) || (opcode_i[5:2] == 4'h1) ||
                 (opcode_i[5:2] == 4'h5);
    end

    // Port-level invariants
    always_comb begin
        // R6
        annul_excl_chk: assert (!(annul_o && taken_o));
        // R2
        link_ret_chk: assert (!link_we_o || (link_idx_o == 5'd31 &&
                              link_data_o == pc_i + 32'd8 && taken_o));
        // R1
        jump_tgt_chk: assert (opcode_i[5:1] != 5'h01 ||
                              (taken_o && target_pc_o == {pc_i[31:28], jfield_i, 2'b00}));
        // R8
        fall_seq_chk: assert (taken_o || next_pc_o == pc_i + 32'd4);
        // R9
        idle_op_chk: assert (is_ctl || (!taken_o && !annul_o && !link_we_o));
    end
endmodule

bind bru_next_pc bru_next_pc_chk u_chk (
    .pc_i        (pc_i),
    .opcode_i    (opcode_i),
    .jfield_i    (jfield_i),
    .target_pc_o (target_pc_o),
    .next_pc_o   (next_pc_o),
    .taken_o     (taken_o),
    .annul_o     (annul_o),
    .link_we_o   (link_we_o),
    .link_idx_o  (link_idx_o),
    .link_data_o (link_data_o)
);

// File: tb/sim_bru_next_pc.sv
// Self-checking bench for bru_next_pc: table-driven vectors, then directed
// corner cases.
module sim_bru_next_pc;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [31:0] pc, opa, opb;
    logic [5:0]  opc;
    logic [25:0] jf;
    logic [15:0] off;
    logic [31:0] tgt, nxt, ldata;
    logic        tk, an, lwe;
    logic [4:0]  lidx;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    bru_next_pc u0 (
        .pc_i (pc), .opcode_i (opc), .jfield_i (jf), .offset_i (off),
        .opa_i (opa), .opb_i (opb),
        .target_pc_o (tgt), .next_pc_o (nxt), .taken_o (tk), .annul_o (an),
        .link_we_o (lwe), .link_idx_o (lidx), .link_data_o (ldata)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic [5:0]  op;
        logic [31:0] pc;
        logic [25:0] jf;
        logic [15:0] off;
        logic [31:0] a;
        logic [31:0] b;
        logic        tk;
        logic        an;
        logic        lw;
        logic [31:0] nxt;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        // R1 jump
        '{8'd1, 6'h02, 32'h4000_1000, 26'h000_0100, 16'h0, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0, 32'h4000_0400},
        // R2 jump-and-link, full field
        '{8'd2, 6'h03, 32'hA000_0010, 26'h3FF_FFFF, 16'h0, 32'h0, 32'h0, 1'b1, 1'b0, 1'b1, 32'hAFFF_FFFC},
        // R4 equal / not equal
        '{8'd4, 6'h04, 32'h0000_0100, 26'h0, 16'h0004, 32'd5, 32'd5, 1'b1, 1'b0, 1'b0, 32'h0000_0114},
        '{8'd4, 6'h04, 32'h0000_0100, 26'h0, 16'h0004, 32'd5, 32'd6, 1'b0, 1'b0, 1'b0, 32'h0000_0104},
        // R3 negative offset
        '{8'd3, 6'h05, 32'h0000_0200, 26'h0, 16'hFFFF, 32'd5, 32'd6, 1'b1, 1'b0, 1'b0, 32'h0000_0200},
        '{8'd4, 6'h05, 32'h0000_0200, 26'h0, 16'hFFFF, 32'd9, 32'd9, 1'b0, 1'b0, 1'b0, 32'h0000_0204},
        // R5 signed tests; second operand must not matter
        '{8'd5, 6'h06, 32'h0000_0300, 26'h0, 16'h0002, 32'h0,         32'h1234, 1'b1, 1'b0, 1'b0, 32'h0000_030C},
        '{8'd5, 6'h06, 32'h0000_0300, 26'h0, 16'h0002, 32'h8000_0000, 32'h0,    1'b1, 1'b0, 1'b0, 32'h0000_030C},
        '{8'd5, 6'h06, 32'h0000_0300, 26'h0, 16'h0002, 32'h1,         32'h1,    1'b0, 1'b0, 1'b0, 32'h0000_0304},
        // R3 most negative offset wraps below zero
        '{8'd3, 6'h07, 32'h0000_0400, 26'h0, 16'h8000, 32'h1,         32'h0,    1'b1, 1'b0, 1'b0, 32'hFFFE_0404},
        '{8'd5, 6'h07, 32'h0000_0400, 26'h0, 16'h0001, 32'hFFFF_FFFF, 32'h5,    1'b0, 1'b0, 1'b0, 32'h0000_0404},
        // R6 / R7 likely forms
        '{8'd7, 6'h14, 32'h0000_0500, 26'h0, 16'h0001, 32'd3, 32'd3, 1'b1, 1'b0, 1'b0, 32'h0000_0508},
        '{8'd6, 6'h14, 32'h0000_0500, 26'h0, 16'h0001, 32'd3, 32'd4, 1'b0, 1'b1, 1'b0, 32'h0000_0504},
        '{8'd6, 6'h15, 32'h0000_0600, 26'h0, 16'h0001, 32'd8, 32'd8, 1'b0, 1'b1, 1'b0, 32'h0000_0604},
        '{8'd6, 6'h16, 32'h0000_0700, 26'h0, 16'h0001, 32'd7, 32'd0, 1'b0, 1'b1, 1'b0, 32'h0000_0704},
        '{8'd7, 6'h17, 32'h0000_0800, 26'h0, 16'h0003, 32'd7, 32'd0, 1'b1, 1'b0, 1'b0, 32'h0000_0810},
        // R9 unlisted opcodes, operands equal to tempt a compare
        '{8'd9, 6'h08, 32'h0000_0900, 26'h3, 16'h0001, 32'd1, 32'd1, 1'b0, 1'b0, 1'b0, 32'h0000_0904},
        '{8'd9, 6'h01, 32'h0000_0A00, 26'h3, 16'h0001, 32'd0, 32'd0, 1'b0, 1'b0, 1'b0, 32'h0000_0A04},
        // R8 fall-through wraps at top of address space
        '{8'd8, 6'h05, 32'hFFFF_FFFC, 26'h0, 16'h0010, 32'd2, 32'd2, 1'b0, 1'b0, 1'b0, 32'h0000_0000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [5:0] o, input logic [31:0] p, input logic [25:0] j,
                         input logic [15:0] f, input logic [31:0] a, input logic [31:0] b);
        @(posedge clk);
        opc = o; pc = p; jf = j; off = f; opa = a; opb = b;
        @(negedge clk);
    endtask

    initial begin
        opc = '0; pc = '0; jf = '0; off = '0; opa = '0; opb = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 idle state with all-zero inputs
        chk("R9 idle taken", {31'b0, tk}, 32'd0);
        chk("R9 idle annul", {31'b0, an}, 32'd0);
        chk("R9 idle link", {31'b0, lwe}, 32'd0);
        chk("R8 idle next", nxt, 32'd4);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].op, VECS[i].pc, VECS[i].jf, VECS[i].off, VECS[i].a, VECS[i].b);
            chk($sformatf("R%0d vec%0d taken", VECS[i].req, i), {31'b0, tk}, {31'b0, VECS[i].tk});
            chk($sformatf("R%0d vec%0d annul", VECS[i].req, i), {31'b0, an}, {31'b0, VECS[i].an});
            chk($sformatf("R%0d vec%0d link", VECS[i].req, i), {31'b0, lwe}, {31'b0, VECS[i].lw});
            chk($sformatf("R%0d vec%0d next", VECS[i].req, i), nxt, VECS[i].nxt);
        end

        // R2 link payload
        drive(6'h03, 32'h1234_5670, 26'h155_5555, 16'h0, 32'h0, 32'h0);
        chk("R2 link idx", {27'b0, lidx}, 32'd31);
        chk("R2 link data", ldata, 32'h1234_5678);
        chk("R1 jal target", tgt, 32'h1555_5554);
        // R3 target reported even when branch falls through
        drive(6'h04, 32'h0000_1000, 26'h0, 16'hFFFE, 32'd1, 32'd2);
        chk("R3 target not-taken", tgt, 32'h0000_0FFC);
        chk("R7 normal not-taken annul", {31'b0, an}, 32'd0);
        // R5 second operand ignored by signed test
        drive(6'h07, 32'h0000_2000, 26'h0, 16'h0001, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        chk("R5 max positive taken", {31'b0, tk}, 32'd1);
        chk("R5 max positive next", nxt, 32'h0000_2008);
        // R6 likely not-taken with most negative operand on 0x17
        drive(6'h17, 32'h0000_3000, 26'h0, 16'h0001, 32'h8000_0000, 32'h0);
        chk("R6 likely gtz neg annul", {31'b0, an}, 32'd1);
        // R7 jumps never annul
        drive(6'h02, 32'h0000_3000, 26'h1, 16'h0, 32'h0, 32'h1);
        chk("R7 jump annul", {31'b0, an}, 32'd0);
        chk("R2 plain jump no link", {31'b0, lwe}, 32'd0);
        // R9 opcode adjacent to likely row
        drive(6'h18, 32'h0000_4000, 26'h0, 16'h0001, 32'h0, 32'h0);
        chk("R9 op18 taken", {31'b0, tk}, 32'd0);
        chk("R9 op18 next", nxt, 32'h0000_4004);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule